// File: doc/BRIEF.md
# Page Latch and Timed Write-Cycle Sequencer for a Serial EEPROM

This block sits behind a serial-bus slave front end and in front of a byte-wide storage array. A page-open strobe carries the first byte address of a write command. The block then fetches the whole 32-byte page that holds that address into a local latch. Each data byte received afterwards is merged into the latch at a column pointer. The pointer advances by one and wraps inside the page. When the front end reports a stop, the block samples the write-protect level. If writing is allowed and at least one byte was received, it runs a timed write cycle. During that cycle it rewrites every byte of the page to the array and holds busy high for a fixed number of clocks.

The array is a synchronous single-port-write, single-port-read RAM model inside the block. Its write port is brought out so the commit traffic can be observed. The cycle length is a parameter in system clocks. Silicon would use a value near 5 ms. Simulation uses a short one.

Top module: `eeprom_page_commit`

## Requirements
- R1: A page-open selects the page whose base is the open address with its low 5 bits cleared. That page's existing array contents are loaded into the latch before the commit uses them.
- R2: Each accepted byte is stored at the current column, and the column then advances modulo 32. The column starts at the low 5 bits of the open address. Wrapping never reaches another page.
- R3: When more than 32 bytes are pushed before the stop, a later byte for a column replaces the earlier one, so the last byte pushed to each column is committed.
- R4: If write protect is high when the stop is sampled, no cycle starts, no array write occurs, busy stays low, and a new page-open on the next clock is accepted.
- R5: Changing write protect after the stop has no effect on a running cycle: its length and its written data are unchanged.
- R6: After an accepted stop, busy_o is high from the next clock for exactly CYCLE_CLKS clocks. Array writes happen only while busy_o is high.
- R7: A cycle writes all 32 bytes of the page, columns 0 to 31 in ascending order, one per clock, in its first 32 clocks. Columns not pushed are rewritten with their previous contents.
- R8: A stop with no byte pushed since the page-open starts no cycle and writes nothing.
- R9: Page-open, byte push and stop strobes that arrive while busy_o is high are ignored.
- R10: After reset, busy_o and mem_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| open_i | input | 1 | Page-open strobe, one clock |
| open_addr_i | input | ADDR_W | Start byte address for the page-open |
| push_i | input | 1 | Data byte strobe, one clock |
| push_data_i | input | 8 | Data byte with push_i |
| stop_i | input | 1 | Stop strobe, one clock |
| wp_i | input | 1 | Write-protect level, sampled at the stop |
| busy_o | output | 1 | High for the whole write cycle |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
A wrong column pointer or a lost dirty flag only shows up at the next commit. It appears as a wrong byte at a specific address in the 32-write burst that starts one clock after the stop. A faulty preload surfaces the same way, as an untouched column whose old contents were not kept. The bench keeps a full byte model of the pages it touches, so every refresh write is compared against it. Faults in the cycle counter or in the write-protect sampling show up at once as a wrong busy length or an unexpected burst.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LOAD   = 2'd1,
    PH_OPEN   = 2'd2,
    PH_COMMIT = 2'd3
  } phase_e;
endpackage

// File: rtl/eepc_ram.sv
module eepc_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/eepc_page_latch.sv
module eepc_page_latch #(
  parameter int COLS   = 32,
  parameter int DATA_W = 8,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [COL_W-1:0]  push_col_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              ld_i,
  input  logic [COL_W-1:0]  ld_col_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              dirty_any_o
);
  logic [DATA_W-1:0] byte_q [COLS];
  logic [COLS-1:0]   dirty_q;

  for (genvar g = 0; g < COLS; g++) begin : g_col
    logic hit_push, hit_ld;
    assign hit_push = push_i && (push_col_i == COL_W'(g));
    // preload never overwrites a byte already pushed
    assign hit_ld   = ld_i && (ld_col_i == COL_W'(g)) && !dirty_q[g];

    always_ff @(posedge clk_i) begin
      if (hit_push)    byte_q[g] <= push_data_i;
      else if (hit_ld) byte_q[g] <= ld_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dirty_q[g] <= 1'b0;
      else if (clr_i)    dirty_q[g] <= 1'b0;
      else if (hit_push) dirty_q[g] <= 1'b1;
    end
  end

  assign rd_data_o   = byte_q[rd_col_i];
  assign dirty_any_o = |dirty_q;
endmodule

// File: rtl/eepc_seq.sv
module eepc_seq
  import eepc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int COLS       = 32,
  parameter int CYCLE_CLKS = 1000000,
  localparam int COL_W = $clog2(COLS),
  localparam int PG_W  = ADDR_W - COL_W,
  localparam int CYC_W = $clog2(CYCLE_CLKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] open_addr_i,
  input  logic              push_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              dirty_any_i,
  output phase_e            phase_o,
  output logic              clr_o,
  output logic              push_o,
  output logic [COL_W-1:0]  push_col_o,
  output logic              ld_o,
  output logic [COL_W-1:0]  ld_col_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [COL_W-1:0]  rd_col_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              busy_o
);
  phase_e            phase_q;
  logic [PG_W-1:0]   page_q;
  logic [COL_W-1:0]  col_q;
  logic [COL_W:0]    ld_cnt_q;
  logic [CYC_W-1:0]  cyc_q;
  logic              pend_q, pend_wp_q;

  logic accept_open, load_done, eff_stop, eff_wp, will_dirty;

  assign accept_open = open_i && (phase_q != PH_COMMIT);
  assign push_o      = push_i && !accept_open &&
                       ((phase_q == PH_OPEN) || (phase_q == PH_LOAD && !pend_q));
  assign load_done   = (phase_q == PH_LOAD) && (ld_cnt_q == (COL_W+1)'(COLS));
  assign eff_stop    = pend_q || stop_i;
  assign eff_wp      = pend_q ? pend_wp_q : wp_i;
  assign will_dirty  = dirty_any_i || push_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      page_q    <= '0;
      col_q     <= '0;
      ld_cnt_q  <= '0;
      cyc_q     <= '0;
      pend_q    <= 1'b0;
      pend_wp_q <= 1'b0;
    end else if (accept_open) begin
      phase_q  <= PH_LOAD;
      page_q   <= open_addr_i[ADDR_W-1:COL_W];
      col_q    <= open_addr_i[COL_W-1:0];
      ld_cnt_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (push_o) col_q <= col_q + 1'b1;
      unique case (phase_q)
        PH_LOAD: begin
          ld_cnt_q <= ld_cnt_q + 1'b1;
          if (stop_i && !pend_q) begin
            pend_q    <= 1'b1;
            pend_wp_q <= wp_i;
          end
          if (load_done) begin
            cyc_q  <= '0;
            pend_q <= 1'b0;
            if (!eff_stop)                    phase_q <= PH_OPEN;
            else if (will_dirty && !eff_wp)   phase_q <= PH_COMMIT;
            else                              phase_q <= PH_IDLE;
          end
        end
        PH_OPEN: begin
          cyc_q <= '0;
          if (stop_i) phase_q <= (will_dirty && !wp_i) ? PH_COMMIT : PH_IDLE;
        end
        PH_COMMIT: begin
          cyc_q <= cyc_q + 1'b1;
          if (cyc_q == CYC_W'(CYCLE_CLKS - 1)) phase_q <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign clr_o      = accept_open;
  assign push_col_o = col_q;
  assign ld_o       = (phase_q == PH_LOAD) && (ld_cnt_q != '0);
  assign ld_col_o   = COL_W'(ld_cnt_q - 1'b1);
  assign raddr_o    = {page_q, ld_cnt_q[COL_W-1:0]};
  assign rd_col_o   = cyc_q[COL_W-1:0];
  assign busy_o     = (phase_q == PH_COMMIT);
  assign mem_we_o   = busy_o && (cyc_q < CYC_W'(COLS));
  assign mem_addr_o = {page_q, cyc_q[COL_W-1:0]};
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
  import eepc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 1000000,
  localparam int DATA_W = 8,
  localparam int COL_W  = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] open_addr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  phase_e            phase;
  logic              clr, push_ok, ld, dirty_any;
  logic [COL_W-1:0]  push_col, ld_col, rd_col;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] rdata;

  eepc_seq #(
    .ADDR_W(ADDR_W), .COLS(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)
  ) u_seq (
    .clk_i, .rst_ni, .open_i, .open_addr_i, .push_i, .stop_i, .wp_i,
    .dirty_any_i(dirty_any),
    .phase_o(phase), .clr_o(clr), .push_o(push_ok), .push_col_o(push_col),
    .ld_o(ld), .ld_col_o(ld_col), .raddr_o(raddr), .rd_col_o(rd_col),
    .mem_we_o, .mem_addr_o, .busy_o
  );

  eepc_page_latch #(.COLS(PAGE_BYTES), .DATA_W(DATA_W)) u_latch (
    .clk_i, .rst_ni, .clr_i(clr),
    .push_i(push_ok), .push_col_i(push_col), .push_data_i,
    .ld_i(ld), .ld_col_i(ld_col), .ld_data_i(rdata),
    .rd_col_i(rd_col), .rd_data_o(mem_wdata_o), .dirty_any_o(dirty_any)
  );

  eepc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i, .we_i(mem_we_o), .waddr_i(mem_addr_o), .wdata_i(mem_wdata_o),
    .raddr_i(raddr), .rdata_o(rdata)
  );
endmodule

// File: rtl/eepc_checker.sv
module eepc_checker
  import eepc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 1000000,
  localparam int COL_W = $clog2(PAGE_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input phase_e            phase,
  input logic              dirty_any
);
  logic [31:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + 1;
    else             busy_len_q <= '0;
  end

  assert_we_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  assert_busy_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_len_q == CYCLE_CLKS);

  assert_wp_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_OPEN && stop_i && wp_i) |=> !busy_o);

  assert_empty_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_OPEN && stop_i && !dirty_any) |=> !busy_o);

  assert_burst_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> mem_addr_o[COL_W-1:0] == '0);

  assert_burst_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o[COL_W-1:0] != '1) |=>
      (mem_we_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

  assert_burst_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o[COL_W-1:0] == '1) |=> !mem_we_o);
endmodule

bind eeprom_page_commit eepc_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .wp_i(wp_i),
  .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .phase(phase), .dirty_any(dirty_any)
);

// File: tb/eeprom_page_commit_tb.sv
module eeprom_page_commit_tb;
  localparam int CYC = 48;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        open_i = 1'b0;
  logic [11:0] open_addr_i = '0;
  logic        push_i = 1'b0;
  logic [7:0]  push_data_i = '0;
  logic        stop_i = 1'b0;
  logic        wp_i = 1'b0;
  logic        busy_o, mem_we_o;
  logic [11:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;

  int checks = 0;
  int errors = 0;
  int wr_n = 0;
  logic [11:0] wr_addr [64];
  logic [7:0]  wr_data [64];
  logic [7:0]  model [4096];

  always #2.5 clk = ~clk;

  eeprom_page_commit #(.ADDR_W(12), .PAGE_BYTES(32), .CYCLE_CLKS(CYC)) u_dut (
    .clk_i(clk), .rst_ni, .open_i, .open_addr_i, .push_i, .push_data_i,
    .stop_i, .wp_i, .busy_o, .mem_we_o, .mem_addr_o, .mem_wdata_o
  );

  always @(negedge clk) begin
    if (mem_we_o) begin
      if (wr_n < 64) begin
        wr_addr[wr_n] = mem_addr_o;
        wr_data[wr_n] = mem_wdata_o;
      end
      wr_n = wr_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int col_next(input int c);
    return (c + 1) % 32;
  endfunction

  task automatic run_cmd(input logic [11:0] a, input int n, input logic wp,
                         input bit wtog, input bit poke, input string tag);
    logic [7:0] img [32];
    int base, col, bcnt;
    bit go;
    base = int'(a) & ~31;
    for (int k = 0; k < 32; k++) img[k] = model[base + k];
    @(negedge clk); open_i = 1'b1; open_addr_i = a;
    @(negedge clk); open_i = 1'b0;
    repeat (40) @(negedge clk);
    col = int'(a[4:0]);
    for (int j = 0; j < n; j++) begin
      logic [7:0] d;
      d = 8'($urandom);
      push_i = 1'b1; push_data_i = d;
      img[col] = d;
      col = col_next(col);
      @(negedge clk); push_i = 1'b0;
      @(negedge clk);
    end
    wr_n = 0;
    stop_i = 1'b1; wp_i = wp;
    @(negedge clk); stop_i = 1'b0;
    go = (n > 0) && !wp;
    bcnt = 0;
    while (busy_o && bcnt < CYC + 4) begin
      bcnt++;
      if (wtog) wp_i = ~wp_i;
      if (poke && bcnt == 3) begin
        open_i = 1'b1; open_addr_i = a ^ 12'h040;
        push_i = 1'b1; push_data_i = 8'hA5; stop_i = 1'b1;
      end else begin
        open_i = 1'b0; push_i = 1'b0; stop_i = 1'b0;
      end
      @(negedge clk);
    end
    open_i = 1'b0; push_i = 1'b0; stop_i = 1'b0; wp_i = 1'b0;
    chk(bcnt == (go ? CYC : 0), "R6", {tag, " busy length"}, bcnt, go ? CYC : 0);
    chk(wr_n == (go ? 32 : 0), tag, "write count", wr_n, go ? 32 : 0);
    if (go && wr_n == 32) begin
      for (int k = 0; k < 32; k++) begin
        chk(wr_addr[k] == 12'(base + k), tag, "write addr", wr_addr[k], base + k);
        chk(wr_data[k] == img[k], tag, "write data", wr_data[k], img[k]);
        model[base + k] = img[k];
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 4096; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R10", "busy after reset", busy_o, 0);
    chk(mem_we_o == 1'b0, "R10", "we after reset", mem_we_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0 && mem_we_o == 1'b0, "R10", "idle after release", busy_o, 0);

    for (int p = 0; p < 8; p++) run_cmd(12'(p * 32), 32, 1'b0, 1'b0, 1'b0, "R7");

    run_cmd(12'h045, 1, 1'b0, 1'b0, 1'b0, "R1");
    run_cmd(12'h07E, 5, 1'b0, 1'b0, 1'b0, "R2");
    run_cmd(12'h0A3, 40, 1'b0, 1'b0, 1'b0, "R3");
    run_cmd(12'h0C0, 3, 1'b1, 1'b0, 1'b0, "R4");
    run_cmd(12'h0C0, 2, 1'b0, 1'b0, 1'b0, "R4");
    run_cmd(12'h0E1, 4, 1'b0, 1'b1, 1'b0, "R5");
    run_cmd(12'h010, 0, 1'b0, 1'b0, 1'b0, "R8");
    run_cmd(12'h031, 3, 1'b0, 1'b0, 1'b1, "R9");
    run_cmd(12'h031, 1, 1'b0, 1'b0, 1'b0, "R9");

    for (int r = 0; r < 24; r++) begin
      int pg, c, n;
      logic wp;
      pg = int'($urandom % 8);
      c  = int'($urandom % 32);
      n  = int'($urandom % 41);
      wp = (($urandom % 8) == 0);
      run_cmd(12'(pg * 32 + c), n, wp, 1'b0, 1'b0, "R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule